// File: doc/BRIEF.md
# Debug Entry and Status Controller

This block is the control and status slice that sits between an external debugger and a processor core. It takes a halt request from the system, moves a small state machine into debug state, and answers with an acknowledge output. The reason for the entry is kept in a status word. The debugger can also force the acknowledge high through a status bit. A later write to a restart bit in the same word leaves debug state.

The block also holds a two-way mailbox between the debugger and the core. Each direction has one data word and a full flag. The two flags drive two interrupt-style outputs directly: one signals "data waiting for the core" and the other signals "core may send". A small set of configuration bits completes the block. One is a no-power-down control bit that appears on an output. Another is a status view of the live power-down request input. The last is an OS-lock bit whose value at reset comes from a strap input.

The debugger uses a single-cycle select/write bus with a combinational read path. The core uses two strobes: one consumes the receive word and one deposits a transmit word.

Top module: `dbg_ctl_unit`

## Requirements
- R1: `halt_req_i` sampled high at a rising edge while in normal state puts the block in debug state from the next cycle. At that point STATUS[0] (address 0) reads 1 and STATUS[5:2] reads 4'b0100.
- R2: `halt_ack_o` rises in the same cycle that STATUS[0] becomes 1. It stays high while in debug state, whatever the level of `halt_req_i`. Before that edge, the held request alone leaves it low.
- R3: A debugger write of 1 to STATUS[10] drives `halt_ack_o` high from the next cycle, even in normal state. Writing 0 to that bit releases the override. STATUS[10] reads back the override.
- R4: A debugger write to STATUS with bit [1] = 1, made in debug state while `halt_req_i` is low, returns the block to normal state on the next cycle. After that, `halt_ack_o` is low unless STATUS[10] is set. STATUS[5:2] keeps 4'b0100.
- R5: A debugger write to address 1 while the receive flag is clear stores the word and sets the receive-full flag STATUS[30] on the next cycle. `cpu_rx_rd_i` clears the flag. `rx_irq_o` always equals STATUS[30], and `cpu_rdata_o` shows the stored word.
- R6: `cpu_tx_wr_i` while the transmit flag is clear stores `cpu_wdata_i` and sets the transmit-full flag STATUS[29] on the next cycle. A debugger read of address 2 returns the word and clears the flag. `tx_irq_o` always equals the inverse of STATUS[29].
- R7: A write into a mailbox word whose full flag is already set is ignored. This holds for debugger writes to address 1 and for core writes to the transmit word, and the stored data stays unchanged.
- R8: `no_pwrdn_o` equals bit [0] of the power control word (address 3, read/write) from the cycle after the write.
- R9: Bit [0] of the power status word (address 4) reads the live level of `pwrdn_req_i`, with no register in the path.
- R10: On reset the OS-lock bit (address 5, bit [0], read/write) takes the value of `lock_init_i`.
- R11: After reset, all other state is zero: STATUS reads 0, `halt_ack_o` is 0, `rx_irq_o` is 0, `tx_irq_o` is 1 and `no_pwrdn_o` is 0. Reads of unmapped addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | External request to enter debug state |
| lock_init_i | input | 1 | Strap giving the OS-lock value at reset |
| pwrdn_req_i | input | 1 | Power-down request level |
| dbg_sel_i | input | 1 | Debugger bus access select |
| dbg_wr_i | input | 1 | Debugger bus write (1) or read (0) |
| dbg_addr_i | input | ADDR_W | Debugger word address |
| dbg_wdata_i | input | 32 | Debugger write data |
| dbg_rdata_o | output | 32 | Debugger read data, combinational |
| cpu_rx_rd_i | input | 1 | Core consumes the receive word |
| cpu_tx_wr_i | input | 1 | Core deposits a transmit word |
| cpu_wdata_i | input | 32 | Core transmit data |
| cpu_rdata_o | output | 32 | Receive word as seen by the core |
| halt_ack_o | output | 1 | Debug acknowledge |
| rx_irq_o | output | 1 | Receive word waiting for the core |
| tx_irq_o | output | 1 | Transmit word free for the core |
| no_pwrdn_o | output | 1 | No-power-down control |

## Verification
Every registered result appears one cycle after the edge that samples its stimulus. This covers debug entry and exit, the override, both mailbox flags, the power control bit and the lock write. Reads and the power status bit are combinational in the same cycle. The bench drives every input on the falling edge. It looks at the outputs just after the next falling edge, so exactly one rising edge lies between a stimulus and the sample. For same-cycle results, it samples a moment after driving the address, before any edge. The halt check also samples between the request and the edge to confirm that the acknowledge has not yet risen.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int REG_W      = 32;
  localparam int METHOD_W   = 4;
  localparam int B_HALTED   = 0;
  localparam int B_RESTART  = 1;
  localparam int B_MLO      = 2;
  localparam int B_OVR      = 10;
  localparam int B_TXFULL   = 29;
  localparam int B_RXFULL   = 30;
  localparam logic [METHOD_W-1:0] ENTRY_EXT_HALT = 4'b0100;

  typedef enum logic [2:0] {
    A_STATUS = 3'd0,
    A_RXDATA = 3'd1,
    A_TXDATA = 3'd2,
    A_PWRCTL = 3'd3,
    A_PWRSTS = 3'd4,
    A_LOCK   = 3'd5
  } reg_addr_e;

  function automatic logic [REG_W-1:0] pack_status(
      input logic halted, input logic [METHOD_W-1:0] method,
      input logic ovr, input logic txf, input logic rxf);
    logic [REG_W-1:0] s;
    s = '0;
    s[B_HALTED] = halted;
    s[B_MLO +: METHOD_W] = method;
    s[B_OVR] = ovr;
    s[B_TXFULL] = txf;
    s[B_RXFULL] = rxf;
    return s;
  endfunction

  function automatic logic [REG_W-1:0] bit0_word(input logic b);
    return {{(REG_W-1){1'b0}}, b};
  endfunction
endpackage

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req_i,
  input  logic                restart_i,
  input  logic                ovr_wr_i,
  input  logic                ovr_val_i,
  output logic                halted_o,
  output logic [METHOD_W-1:0] method_o,
  output logic                ovr_o,
  output logic                ack_o,
  output logic                enter_evt_o,
  output logic                exit_evt_o
);
  logic                halted_q;
  logic [METHOD_W-1:0] method_q;
  logic                ovr_q;

  assign enter_evt_o = !halted_q && halt_req_i;
  assign exit_evt_o  = halted_q && restart_i && !halt_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      method_q <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (enter_evt_o) begin
        halted_q <= 1'b1;
        method_q <= ENTRY_EXT_HALT;
      end else if (exit_evt_o) begin
        halted_q <= 1'b0;
      end
      if (ovr_wr_i) ovr_q <= ovr_val_i;
    end
  end

  assign halted_o = halted_q;
  assign method_o = method_q;
  assign ovr_o    = ovr_q;
  assign ack_o    = halted_q || ovr_q;

  a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt_o |=> (halted_q && method_q == ENTRY_EXT_HALT));
  a_r2_ack_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> ack_o);
  a_r3_override: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_wr_i && ovr_val_i) |=> ack_o);
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt_o |=> (!halted_q && $stable(method_q)));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_wr_i,
  input  logic [REG_W-1:0] rx_wdata_i,
  input  logic             rx_rd_i,
  input  logic             tx_wr_i,
  input  logic [REG_W-1:0] tx_wdata_i,
  input  logic             tx_rd_i,
  output logic [REG_W-1:0] rx_data_o,
  output logic [REG_W-1:0] tx_data_o,
  output logic             rx_full_o,
  output logic             tx_full_o
);
  logic [REG_W-1:0] rx_q, tx_q;
  logic             rx_full_q, tx_full_q;
  logic             rx_load, rx_drain, tx_load, tx_drain;

  assign rx_load  = rx_wr_i && !rx_full_q;
  assign rx_drain = rx_rd_i && rx_full_q;
  assign tx_load  = tx_wr_i && !tx_full_q;
  assign tx_drain = tx_rd_i && tx_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0; tx_q <= '0;
      rx_full_q <= 1'b0; tx_full_q <= 1'b0;
    end else begin
      if (rx_load) begin
        rx_q <= rx_wdata_i;
        rx_full_q <= 1'b1;
      end else if (rx_drain) begin
        rx_full_q <= 1'b0;
      end
      if (tx_load) begin
        tx_q <= tx_wdata_i;
        tx_full_q <= 1'b1;
      end else if (tx_drain) begin
        tx_full_q <= 1'b0;
      end
    end
  end

  assign rx_data_o = rx_q;
  assign tx_data_o = tx_q;
  assign rx_full_o = rx_full_q;
  assign tx_full_o = tx_full_q;

  a_r5_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rx_full_q);
  a_r5_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drain |=> !rx_full_q);
  a_r6_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_full_q);
  a_r6_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drain |=> !tx_full_q);
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_q && rx_wr_i) |=> $stable(rx_q));
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full_q && tx_wr_i) |=> $stable(tx_q));
endmodule

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_init_i,
  input  logic pwr_wr_i,
  input  logic lock_wr_i,
  input  logic wbit_i,
  output logic no_pwrdn_o,
  output logic lock_o
);
  logic no_pwrdn_q, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      no_pwrdn_q <= 1'b0;
      lock_q     <= lock_init_i;
    end else begin
      if (pwr_wr_i)  no_pwrdn_q <= wbit_i;
      if (lock_wr_i) lock_q     <= wbit_i;
    end
  end

  assign no_pwrdn_o = no_pwrdn_q;
  assign lock_o     = lock_q;

  a_r8_pwr_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_wr_i |=> (no_pwrdn_o == $past(wbit_i)));
  a_r10_lock_wr: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr_i |=> (lock_o == $past(wbit_i)));
endmodule

// File: rtl/dbg_ctl_unit.sv
module dbg_ctl_unit
  import dbg_ctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req_i,
  input  logic              lock_init_i,
  input  logic              pwrdn_req_i,
  input  logic              dbg_sel_i,
  input  logic              dbg_wr_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  input  logic [31:0]       dbg_wdata_i,
  output logic [31:0]       dbg_rdata_o,
  input  logic              cpu_rx_rd_i,
  input  logic              cpu_tx_wr_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic [31:0]       cpu_rdata_o,
  output logic              halt_ack_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o,
  output logic              no_pwrdn_o
);
  logic                dbg_wr, dbg_rd;
  logic                wr_status, wr_rx, rd_tx, wr_pwr, wr_lock;
  logic                halted, ovr, enter_evt, exit_evt;
  logic [METHOD_W-1:0] method;
  logic [REG_W-1:0]    rx_data, tx_data;
  logic                rx_full, tx_full, lock_bit;

  assign dbg_wr    = dbg_sel_i && dbg_wr_i;
  assign dbg_rd    = dbg_sel_i && !dbg_wr_i;
  assign wr_status = dbg_wr && (dbg_addr_i == ADDR_W'(A_STATUS));
  assign wr_rx     = dbg_wr && (dbg_addr_i == ADDR_W'(A_RXDATA));
  assign rd_tx     = dbg_rd && (dbg_addr_i == ADDR_W'(A_TXDATA));
  assign wr_pwr    = dbg_wr && (dbg_addr_i == ADDR_W'(A_PWRCTL));
  assign wr_lock   = dbg_wr && (dbg_addr_i == ADDR_W'(A_LOCK));

  dbg_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req_i),
    .restart_i(wr_status && dbg_wdata_i[B_RESTART]),
    .ovr_wr_i(wr_status), .ovr_val_i(dbg_wdata_i[B_OVR]),
    .halted_o(halted), .method_o(method), .ovr_o(ovr), .ack_o(halt_ack_o),
    .enter_evt_o(enter_evt), .exit_evt_o(exit_evt)
  );

  dbg_mailbox u_mbox (
    .clk(clk), .rst_n(rst_n),
    .rx_wr_i(wr_rx), .rx_wdata_i(dbg_wdata_i), .rx_rd_i(cpu_rx_rd_i),
    .tx_wr_i(cpu_tx_wr_i), .tx_wdata_i(cpu_wdata_i), .tx_rd_i(rd_tx),
    .rx_data_o(rx_data), .tx_data_o(tx_data),
    .rx_full_o(rx_full), .tx_full_o(tx_full)
  );

  dbg_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .lock_init_i(lock_init_i),
    .pwr_wr_i(wr_pwr), .lock_wr_i(wr_lock), .wbit_i(dbg_wdata_i[0]),
    .no_pwrdn_o(no_pwrdn_o), .lock_o(lock_bit)
  );

  always_comb begin
    dbg_rdata_o = '0;
    unique case (dbg_addr_i)
      ADDR_W'(A_STATUS): dbg_rdata_o = pack_status(halted, method, ovr, tx_full, rx_full);
      ADDR_W'(A_RXDATA): dbg_rdata_o = rx_data;
      ADDR_W'(A_TXDATA): dbg_rdata_o = tx_data;
      ADDR_W'(A_PWRCTL): dbg_rdata_o = bit0_word(no_pwrdn_o);
      ADDR_W'(A_PWRSTS): dbg_rdata_o = bit0_word(pwrdn_req_i);
      ADDR_W'(A_LOCK):   dbg_rdata_o = bit0_word(lock_bit);
      default:           dbg_rdata_o = '0;
    endcase
  end

  assign cpu_rdata_o = rx_data;
  assign rx_irq_o    = rx_full;
  assign tx_irq_o    = !tx_full;

  a_r2_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> halt_ack_o);
  a_r4_exit_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_evt && !dbg_wdata_i[B_OVR]) |=> !halt_ack_o);
  a_r6_tx_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_tx_wr_i && tx_irq_o) |=> !tx_irq_o);
  a_r5_rx_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rx && !rx_irq_o) |=> rx_irq_o);
endmodule

// File: tb/dbg_ctl_unit_bench.sv
module dbg_ctl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_req = 1'b0, lock_init = 1'b0, pwrdn_req = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, cpu_wdata = '0, cpu_rdata;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic        ack, rx_irq, tx_irq, no_pwrdn;
  int          n_checks = 0, n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dbg_ctl_unit u_dbg_ctl_unit (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .lock_init_i(lock_init),
    .pwrdn_req_i(pwrdn_req), .dbg_sel_i(sel), .dbg_wr_i(wr), .dbg_addr_i(addr),
    .dbg_wdata_i(wdata), .dbg_rdata_o(rdata), .cpu_rx_rd_i(cpu_rd),
    .cpu_tx_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .halt_ack_o(ack), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .no_pwrdn_o(no_pwrdn)
  );

  function automatic logic [31:0] st(bit h, int m, bit o, bit t, bit r);
    return 32'(h) + 32'(m) * 4 + 32'(o) * 1024 + 32'(t) * (1 << 29) + 32'(r) * (1 << 30);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic dwr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = '0; #1;
  endtask

  task automatic drd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a; #1 d = rdata;
    @(negedge clk); sel = 0; #1;
  endtask

  task automatic do_reset(bit s);
    @(negedge clk); rst_n = 0; lock_init = s;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      drd(3'd5, r); chk("R10 lock strap", r, 32'(s));
      dwr(3'd5, 32'(1 - s));
      drd(3'd5, r); chk("R10 lock write", r, 32'(1 - s));
    end
    do_reset(0);
    drd(3'd0, r); chk("R11 status reset", r, 0);
    chk("R11 ack/irq/pwr reset", {ack, rx_irq, tx_irq, no_pwrdn}, 32'b0010);
    drd(3'd6, r); chk("R11 unmapped 6", r, 0);
    drd(3'd7, r); chk("R11 unmapped 7", r, 0);

    // R1/R2: held request, entry after edge
    @(negedge clk); halt_req = 1; #1;
    chk("R2 ack before edge", ack, 0);
    @(negedge clk); #1;
    chk("R2 ack after entry", ack, 1);
    halt_req = 0;
    repeat (3) @(negedge clk);
    chk("R2 ack held in debug", ack, 1);
    drd(3'd0, r); chk("R1 status entry", r, st(1, 4, 0, 0, 0));
    // R4 restart without override
    dwr(3'd0, 32'h2);
    chk("R4 ack after restart", ack, 0);
    drd(3'd0, r); chk("R4 status after restart", r, st(0, 4, 0, 0, 0));
    // R3 override in normal state
    dwr(3'd0, 32'h400);
    chk("R3 override ack", ack, 1);
    drd(3'd0, r); chk("R3 override readback", r, st(0, 4, 1, 0, 0));
    dwr(3'd0, 32'h0);
    chk("R3 override release", ack, 0);
    // R4 restart with override kept
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
    dwr(3'd0, 32'h402);
    drd(3'd0, r); chk("R4 restart with override", r, st(0, 4, 1, 0, 0));
    chk("R4 ack kept by override", ack, 1);
    dwr(3'd0, 32'h0);

    // R5/R7 receive sweep
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d, d2;
      d  = 32'(i) * 32'h1111_1111 ^ (32'(i) << 3);
      d2 = ~d;
      dwr(3'd1, d);
      chk("R5 rx_irq set", rx_irq, 1);
      chk("R5 rx data", cpu_rdata, d);
      drd(3'd0, r); chk("R5 status rx full", r, st(0, 4, 0, 0, 1));
      dwr(3'd1, d2);
      chk("R7 rx write ignored", cpu_rdata, d);
      @(negedge clk); cpu_rd = 1;
      @(negedge clk); cpu_rd = 0; #1;
      chk("R5 rx_irq cleared", rx_irq, 0);
    end

    // R6/R7 transmit sweep
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      d = 32'(i) * 32'h0F0F_1357 + 32'(i);
      @(negedge clk); cpu_wr = 1; cpu_wdata = d;
      @(negedge clk); cpu_wdata = ~d; #1;
      chk("R6 tx_irq drops", tx_irq, 0);
      @(negedge clk); cpu_wr = 0; #1;
      drd(3'd0, r); chk("R6 status tx full", r, st(0, 4, 0, 1, 0));
      drd(3'd2, r); chk("R7 tx write ignored / R6 data", r, d);
      chk("R6 tx_irq after drain", tx_irq, 1);
    end

    // R8/R9 power sweep
    for (int p = 0; p < 2; p++)
      for (int q = 0; q < 2; q++) begin
        dwr(3'd3, 32'(p));
        chk("R8 no_pwrdn", no_pwrdn, p[0]);
        @(negedge clk); pwrdn_req = q[0];
        sel = 1; wr = 0; addr = 3'd4; #1;
        chk("R9 pwr status live", rdata, 32'(q));
        @(negedge clk); sel = 0;
      end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule